// File: doc/BRIEF.md
# Multichannel SAR ADC Serial Controller

This block sits on the host side of an eight-input successive-approximation converter and runs its four-wire serial link. A system clock is divided down to make the serial clock. Each conversion is one frame of sixteen serial clock cycles. The frame opens when the chip select goes low, and that edge also samples the input and starts the conversion. During every frame the controller shifts a 16-bit command word out, most significant bit first, and shifts the 16-bit response word in. The response always belongs to the conversion that the same frame started.

While the run input is high, the controller starts frames one after another. Each command addresses the next enabled channel in a host-supplied mask, so the conversions step through the chosen channels. The command also carries the input-span and output-coding selections. Each finished frame produces a registered sample with its channel tag and a one-cycle valid strobe. Between frames the chip select stays high for a programmable quiet gap. After reset, a power-up wait must pass before the first frame is issued.

Top module: `sar_adc_ctrl`

## Requirements
- R1: While reset is held and directly after it: adc_cs_n = 1, adc_sclk = 1, smp_valid = 0, busy = 0.
- R2: After reset is released, adc_cs_n stays high for at least PWRUP_CYC clock cycles before the first frame.
- R3: A frame is one adc_cs_n low window containing exactly 16 adc_sclk falling edges. adc_sclk is high whenever adc_cs_n is high. Each adc_sclk low phase lasts HALF_DIV clock cycles.
- R4: The command word is sent MSB first on adc_din and changes only after adc_sclk rising edges, never across a falling edge. Its layout is: bit 15 = 1 (write), bit 14 = 0, bits 13:11 = channel address, bits 10:9 = 2'b11 (normal power), bit 8 = 0, bit 7 = range_sel, bit 6 = coding_sel, bits 5:0 = 0.
- R5: adc_dout is captured on the 16 adc_sclk rising edges, MSB first. Response bits 14:12 appear on smp_chan and bits 11:0 on smp_data, together with a smp_valid pulse exactly one clock wide.
- R6: Each frame addresses the next channel after the previously addressed one whose chan_mask bit is set, wrapping from 7 to 0. After reset the search starts at channel 0.
- R7: adc_cs_n stays high for at least QUIET_CYC clock cycles between frames. busy is high from the chip-select falling edge until the quiet gap has elapsed.
- R8: With chan_mask all zero, no frame starts even while run is high.
- R9: With run low, no new frame starts. A frame already in progress completes and still delivers its sample.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Keep issuing frames while high |
| chan_mask | input | 8 | One bit per channel to convert |
| range_sel | input | 1 | Span control bit placed in the command |
| coding_sel | input | 1 | Output coding control bit placed in the command |
| adc_cs_n | output | 1 | Active-low frame select |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_din | output | 1 | Command bit stream to the converter |
| adc_dout | input | 1 | Response bit stream from the converter |
| smp_data | output | 12 | Result field of the last response |
| smp_chan | output | 3 | Channel tag of the last response |
| smp_valid | output | 1 | One-cycle strobe for a new sample |
| busy | output | 1 | Frame or quiet gap in progress |

## Verification
The hardest case to reach is the one-frame offset between the address a command carries and the channel a response reports. A wrong walk through the mask shows up only when a sparse or changed mask sends the pointer across the wrap point. A converter model in the bench latches each command at the end of its frame and answers the next frame with a code derived from the channel, span and coding. The stimulus table switches masks, including single-bit and wrap-around patterns, between runs and through a mid-test reset. This forces the pointer across the wrap and back to its starting point, while the bench predicts the walk on its own.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int FRAME_LEN = 16;
  localparam int CH_W      = 3;
  localparam int NCH       = 1 << CH_W;
  localparam int DATA_W    = 12;

  // command word field positions, decoded by the converter
  localparam int CMD_WR   = 15;
  localparam int CMD_ADDR = 11;
  localparam int CMD_PM   = 9;
  localparam int CMD_RNG  = 7;
  localparam int CMD_COD  = 6;
  // response tag position
  localparam int RSP_TAG  = 12;

  typedef enum logic [2:0] {
    ST_PWRUP, ST_IDLE, ST_LEAD, ST_LOW, ST_HIGH, ST_TAIL, ST_QUIET
  } ctrl_st_t;

  function automatic logic [FRAME_LEN-1:0] build_cmd(
    input logic [CH_W-1:0] addr, input logic rng, input logic cod);
    logic [FRAME_LEN-1:0] w;
    w = '0;
    w[CMD_WR] = 1'b1;
    w[CMD_ADDR +: CH_W] = addr;
    w[CMD_PM +: 2] = 2'b11;
    w[CMD_RNG] = rng;
    w[CMD_COD] = cod;
    return w;
  endfunction
endpackage

// File: rtl/sar_tick.sv
module sar_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(HALF_DIV + 1);
  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !en || tick) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sar_chan_pick.sv
module sar_chan_pick
  import sar_pkg::*;
(
  input  logic [CH_W-1:0] cur,
  input  logic [NCH-1:0]  mask,
  output logic [CH_W-1:0] nxt
);
  always_comb begin
    logic found;
    found = 1'b0;
    nxt   = cur;
    for (int i = 1; i <= NCH; i++) begin
      if (!found && mask[CH_W'(int'(cur) + i)]) begin
        nxt   = CH_W'(int'(cur) + i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_pkg::*;
#(
  parameter int HALF_DIV  = 2,
  parameter int QUIET_CYC = 6,
  parameter int PWRUP_CYC = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [NCH-1:0]    chan_mask,
  input  logic              range_sel,
  input  logic              coding_sel,
  output logic              adc_cs_n,
  output logic              adc_sclk,
  output logic              adc_din,
  input  logic              adc_dout,
  output logic [DATA_W-1:0] smp_data,
  output logic [CH_W-1:0]   smp_chan,
  output logic              smp_valid,
  output logic              busy
);
  localparam int WAIT_MAX = (PWRUP_CYC > QUIET_CYC) ? PWRUP_CYC : QUIET_CYC;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 2);
  localparam int BIT_W    = $clog2(FRAME_LEN);

  ctrl_st_t               state;
  logic [WAIT_W-1:0]      wcnt;
  logic [BIT_W-1:0]       bitc;
  logic [FRAME_LEN-1:0]   tx;
  logic [FRAME_LEN-3:0]   rx;
  logic [FRAME_LEN-2:0]   rx_full;
  logic [CH_W-1:0]        ptr, nxt;
  logic [FRAME_LEN-1:0]   cmd;
  logic                   tick, tick_en;

  assign tick_en = (state == ST_LEAD) || (state == ST_LOW) ||
                   (state == ST_HIGH) || (state == ST_TAIL);
  assign rx_full = {rx, adc_dout};
  assign cmd     = build_cmd(nxt, range_sel, coding_sel);

  sar_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst(rst), .en(tick_en), .tick(tick)
  );

  sar_chan_pick u_pick (
    .cur(ptr), .mask(chan_mask), .nxt(nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_PWRUP;
      wcnt      <= '0;
      bitc      <= '0;
      tx        <= '0;
      rx        <= '0;
      ptr       <= CH_W'(NCH - 1);
      adc_cs_n  <= 1'b1;
      adc_sclk  <= 1'b1;
      adc_din   <= 1'b0;
      smp_data  <= '0;
      smp_chan  <= '0;
      smp_valid <= 1'b0;
      busy      <= 1'b0;
    end else begin
      smp_valid <= 1'b0;
      unique case (state)
        ST_PWRUP: begin
          if (wcnt == WAIT_W'(PWRUP_CYC - 1)) begin
            wcnt  <= '0;
            state <= ST_IDLE;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        ST_IDLE: begin
          if (run && (|chan_mask)) begin
            adc_cs_n <= 1'b0;
            busy     <= 1'b1;
            adc_din  <= cmd[FRAME_LEN-1];
            tx       <= {cmd[FRAME_LEN-2:0], 1'b0};
            ptr      <= nxt;
            bitc     <= '0;
            state    <= ST_LEAD;
          end
        end
        ST_LEAD, ST_HIGH: begin
          if (tick) begin
            adc_sclk <= 1'b0;
            state    <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (tick) begin
            adc_sclk <= 1'b1;
            rx       <= rx_full[FRAME_LEN-3:0];
            if (bitc == BIT_W'(FRAME_LEN - 1)) begin
              smp_valid <= 1'b1;
              smp_chan  <= rx_full[RSP_TAG +: CH_W];
              smp_data  <= rx_full[DATA_W-1:0];
              state     <= ST_TAIL;
            end else begin
              adc_din <= tx[FRAME_LEN-1];
              tx      <= {tx[FRAME_LEN-2:0], 1'b0};
              bitc    <= bitc + 1'b1;
              state   <= ST_HIGH;
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            adc_cs_n <= 1'b1;
            wcnt     <= '0;
            state    <= ST_QUIET;
          end
        end
        ST_QUIET: begin
          if (wcnt == WAIT_W'(QUIET_CYC - 1)) begin
            busy  <= 1'b0;
            wcnt  <= '0;
            state <= ST_IDLE;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- checker logic and assertions ----------------
  logic [WAIT_W-1:0] hi_cnt;
  logic [BIT_W:0]    fall_cnt;
  logic              cs_q, sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt   <= '0;
      fall_cnt <= '0;
      cs_q     <= 1'b1;
      sclk_q   <= 1'b1;
    end else begin
      cs_q   <= adc_cs_n;
      sclk_q <= adc_sclk;
      if (!adc_cs_n) hi_cnt <= '0;
      else if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
      if (cs_q && !adc_cs_n) fall_cnt <= '0;
      else if (!adc_cs_n && sclk_q && !adc_sclk) fall_cnt <= fall_cnt + 1'b1;
    end
  end

  // R3
  cs_idle_sclk_chk: assert property (@(posedge clk) disable iff (rst)
    adc_cs_n |-> adc_sclk);

  // R3
  frame_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_cs_n) |-> (fall_cnt == (BIT_W+1)'(FRAME_LEN)));

  // R4
  din_stable_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_sclk) |-> $stable(adc_din));

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> !smp_valid);

  // R7
  quiet_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_cs_n) |-> (hi_cnt >= WAIT_W'(QUIET_CYC)));

  // R7
  busy_frame_chk: assert property (@(posedge clk) disable iff (rst)
    !adc_cs_n |-> busy);

  // R8
  empty_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (adc_cs_n && chan_mask == '0) |=> adc_cs_n);
endmodule

// File: tb/sim_sar_adc_ctrl.sv
module sim_sar_adc_ctrl;
  localparam int CLK_P = 10;
  localparam int HALF  = 2;
  localparam int QUIET = 6;
  localparam int PWRUP = 40;

  logic clk = 1'b0;
  logic rst, run, range_sel, coding_sel;
  logic [7:0] chan_mask;
  logic adc_cs_n, adc_sclk, adc_din;
  logic adc_dout = 1'b0;
  logic [11:0] smp_data;
  logic [2:0]  smp_chan;
  logic smp_valid, busy;

  always #(CLK_P/2) clk = ~clk;

  sar_adc_ctrl #(.HALF_DIV(HALF), .QUIET_CYC(QUIET), .PWRUP_CYC(PWRUP)) u0 (
    .clk(clk), .rst(rst), .run(run), .chan_mask(chan_mask),
    .range_sel(range_sel), .coding_sel(coding_sel),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_din(adc_din),
    .adc_dout(adc_dout), .smp_data(smp_data), .smp_chan(smp_chan),
    .smp_valid(smp_valid), .busy(busy)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // converter model: code derived from channel, span and coding
  function automatic logic [11:0] mdl_val(input logic [2:0] ch, input logic rng, input logic cod);
    logic [11:0] v;
    v = 12'(int'(ch) * 500 + 165);
    if (!rng) v = v >> 1;
    if (!cod) v = v ^ 12'h800;
    return v;
  endfunction

  logic [2:0]  lat_addr = 3'd0;
  logic        lat_rng = 1'b1, lat_cod = 1'b1;
  logic [15:0] cur_word, din_sr;
  int          fcnt = 0;
  bit          in_frame = 0;
  int          frames = 0;
  int          bptr = 7;
  logic [2:0]  exp_ch [0:255];
  logic [11:0] exp_d  [0:255];
  int          wr = 0, rd = 0, nval = 0;

  always @(negedge adc_cs_n) begin
    cur_word = {1'b0, lat_addr, mdl_val(lat_addr, lat_rng, lat_cod)};
    exp_ch[wr[7:0]] = lat_addr;
    exp_d[wr[7:0]]  = cur_word[11:0];
    wr++;
    fcnt = 0;
    din_sr = '0;
    adc_dout = 1'b0;
    in_frame = 1;
    frames++;
  end

  always @(negedge adc_sclk) begin
    if (in_frame) begin
      fcnt++;
      din_sr = {din_sr[14:0], adc_din};
      if (fcnt <= 16) adc_dout = cur_word[16 - fcnt];
    end
  end

  always @(posedge adc_cs_n) begin
    if (in_frame) begin
      int nx;
      in_frame = 0;
      chk(fcnt == 16, "R3 falls per frame", fcnt, 16);
      chk(din_sr[15] == 1'b1 && din_sr[14] == 1'b0 && din_sr[10:9] == 2'b11 &&
          din_sr[8] == 1'b0 && din_sr[5:0] == 6'd0, "R4 fixed fields", din_sr, 16'h8600);
      chk(din_sr[7] == range_sel, "R4 range bit", din_sr[7], range_sel);
      chk(din_sr[6] == coding_sel, "R4 coding bit", din_sr[6], coding_sel);
      nx = bptr;
      for (int i = 1; i <= 8; i++) begin
        if (chan_mask[(bptr + i) % 8]) begin
          nx = (bptr + i) % 8;
          break;
        end
      end
      chk(din_sr[13:11] == nx[2:0], "R6 channel walk", din_sr[13:11], nx);
      bptr = nx;
      if (din_sr[15]) begin
        lat_addr = din_sr[13:11];
        lat_rng  = din_sr[7];
        lat_cod  = din_sr[6];
      end
    end
  end

  int hi_cnt = 0, low_run = 0;
  bit first_frame = 1;

  always @(negedge clk) begin
    if (rst) begin
      hi_cnt = 0;
      low_run = 0;
      first_frame = 1;
    end else begin
      if (adc_cs_n) hi_cnt++;
      else begin
        if (hi_cnt > 0) begin
          if (first_frame) chk(hi_cnt >= PWRUP, "R2 power-up wait", hi_cnt, PWRUP);
          else             chk(hi_cnt >= QUIET, "R7 quiet gap", hi_cnt, QUIET);
          chk(busy == 1'b1, "R7 busy in frame", busy, 1);
          first_frame = 0;
        end
        hi_cnt = 0;
      end
      if (!adc_sclk) low_run++;
      else begin
        if (low_run > 0) chk(low_run == HALF, "R3 sclk low phase", low_run, HALF);
        low_run = 0;
      end
      if (smp_valid) begin
        if (rd < wr) begin
          chk(smp_chan == exp_ch[rd[7:0]], "R5 channel tag", smp_chan, exp_ch[rd[7:0]]);
          chk(smp_data == exp_d[rd[7:0]], "R5 result", smp_data, exp_d[rd[7:0]]);
          rd++;
        end else begin
          chk(0, "R5 unexpected valid", 1, 0);
        end
        nval++;
      end
    end
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic wait_idle();
    int t;
    t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!(busy == 1'b0 && adc_cs_n == 1'b1) && t < 2000);
    if (t >= 2000) chk(0, "R9 idle timeout", t, 0);
  endtask

  task automatic wait_samples(input int n);
    int t, goal;
    t = 0;
    goal = nval + n;
    while (nval < goal && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(nval >= goal, "R5 sample count", nval, goal);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(adc_cs_n == 1'b1 && adc_sclk == 1'b1 && smp_valid == 1'b0 && busy == 1'b0,
        "R1 reset outputs", {adc_cs_n, adc_sclk, smp_valid, busy}, 4'b1100);
    bptr = 7;
    rst = 1'b0;
  endtask

  // {mask, range, coding, frames}
  localparam logic [17:0] VEC [0:5] = '{
    {8'hFF, 1'b1, 1'b1, 8'd10},
    {8'h81, 1'b1, 1'b0, 8'd5},
    {8'h24, 1'b0, 1'b1, 8'd6},
    {8'h01, 1'b0, 1'b0, 8'd4},
    {8'h80, 1'b1, 1'b1, 8'd3},
    {8'h5A, 1'b1, 1'b0, 8'd9}
  };

  initial begin
    int f0;
    rst = 1'b1; run = 1'b0; chan_mask = 8'h00; range_sel = 1'b1; coding_sel = 1'b1;
    do_reset();
    repeat (10) @(posedge clk);
    #1;
    chk(adc_cs_n == 1'b1 && busy == 1'b0, "R2 quiet during power-up", adc_cs_n, 1);

    for (int k = 0; k < 6; k++) begin
      wait_idle();
      @(posedge clk); #1;
      chan_mask  = VEC[k][17:10];
      range_sel  = VEC[k][9];
      coding_sel = VEC[k][8];
      run = 1'b1;
      wait_samples(int'(VEC[k][7:0]));
      @(posedge clk); #1;
      run = 1'b0;
      wait_idle();
    end

    // R8: empty mask with run high
    @(posedge clk); #1;
    chan_mask = 8'h00;
    run = 1'b1;
    f0 = frames;
    repeat (300) @(negedge clk);
    chk(frames == f0 && adc_cs_n == 1'b1, "R8 empty mask", frames, f0);
    @(posedge clk); #1;
    run = 1'b0;

    // R9: run dropped after one sample, nothing further starts
    @(posedge clk); #1;
    chan_mask = 8'hC3;
    run = 1'b1;
    wait_samples(1);
    @(posedge clk); #1;
    run = 1'b0;
    wait_idle();
    f0 = frames;
    repeat (300) @(negedge clk);
    chk(frames == f0 && busy == 1'b0, "R9 run low stops frames", frames, f0);

    // reset restarts the walk at channel 0 and the power-up wait
    do_reset();
    @(posedge clk); #1;
    chan_mask = 8'hFF;
    range_sel = 1'b0;
    coding_sel = 1'b1;
    run = 1'b1;
    wait_samples(3);
    @(posedge clk); #1;
    run = 1'b0;
    wait_idle();
    chk(rd == wr, "R5 all frames delivered", rd, wr);

    finish_run();
  end
endmodule